// File: doc/BRIEF.md
# Cascadable Up-Counting Timer with Trigger Linking

This block is a 16-bit up-counter driven by a programmable prescaler. It wraps to zero after reaching a programmable period, and the wrap is its overflow event. A trigger output can be linked to the trigger input of a second instance. The linked instance can then count the first one's overflows or be started by it.

The trigger input is taken from one of two sources: the trigger output of a peer instance or a channel input pin. It passes through a synchronizer and an edge detector. A slave controller then uses the detected rising edges in one of three ways:
- as the count clock (external clock mode);
- as a one-time start of the counter (trigger mode);
- not at all (free-running mode).

A synchronization bit holds back the instance's response to its own trigger edges. The delay equals the time the trigger output needs to reach a linked instance, so a master and its slave start counting on the same clock edge. Period and prescaler values are shadowed. A change made while the counter is running takes effect at the next overflow. All configuration arrives on plain input ports.

Top module: `casc_timer`

## Requirements
- R1: The counter advances from 0 to the active period value. On the advance after that value (or any advance while the count is at or above it) it returns to 0.
- R2: With trigger-output select 3'b010, the trigger output is high for exactly one clock, in the cycle just after the counter wrapped to 0.
- R3: With slave mode 3'b111, the counter advances once for each detected rising edge of the selected trigger and ignores the prescaler. Linked to a master's overflow output, the slave count therefore rises by exactly one per master overflow.
- R4: With slave mode 3'b110, the first detected rising edge permanently enables counting. With the sync bit clear, the count first reads 1 after the third clock edge following the edge at which the raw input is first sampled high. Later trigger edges neither restart nor reset the count.
- R5: Trigger-input select 3'b000 chooses the peer trigger input and 3'b100 chooses the channel input. Every other code selects a constant low.
- R6: With the sync bit set, the instance's own trigger response is delayed by three extra clocks. A slave in trigger mode, linked through trigger-output select 3'b001, starts on the same edge as its master, so both counts are equal.
- R7: With trigger-output select 3'b001, the output pulses for one clock per detected trigger edge. The pulse comes one clock after detection and is never delayed by the sync bit. Codes other than 3'b001 and 3'b010 keep the output low.
- R8: After reset the count, trigger output and run status are 0. The count never changes while neither the enable input nor a trigger-mode start is active.
- R9: The prescaler divides the clock by the division value plus 1. With division 1 and period 32, overflows are 66 clocks apart.
- R10: With slave mode 3'b000, trigger edges have no effect: a stopped counter stays stopped and at 0.
- R11: Period and division values are copied into the active registers only while the counter is stopped or at an overflow. A period change made mid-count leaves the current interval unchanged and applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter enable |
| div_val | input | 16 | Prescaler division value (divides by value+1) |
| per_val | input | 16 | Period value (counter wraps after this value) |
| slave_mode | input | 3 | 000 free-running, 110 trigger start, 111 external clock |
| trgi_sel | input | 3 | Trigger source: 000 peer, 100 channel input |
| sync_hold | input | 1 | Delay own trigger response to align a linked slave |
| trgo_sel | input | 3 | Trigger output source: 001 trigger echo, 010 overflow |
| peer_trg_in | input | 1 | Trigger output of another instance |
| ch1_in | input | 1 | Channel input pin |
| cnt_out | output | 16 | Current count |
| trg_out | output | 1 | Trigger output |
| run_out | output | 1 | Counter is enabled (by input or by trigger start) |

## Verification
In a master with the sync bit set, two events can fall on the same clock edge: the master's own delayed trigger-mode start, and the start of a slave that sees the master's trigger echo through its synchronizer. The bench chains two instances this way and raises the channel input. It then expects both counts to read 4 at the tenth edge after the input is first sampled. The same setup is repeated with the sync bit clear, where the counts must read 7 and 4, which shows that the alignment comes from the delay alone. Overflow linking is judged through a scoreboard: each observed master overflow pulse queues the next expected slave count, which must appear three clocks later.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;

    typedef enum logic [2:0] {
        SM_FREE   = 3'b000,
        SM_TRIG   = 3'b110,
        SM_EXTCLK = 3'b111
    } slv_mode_e;

    typedef enum logic [2:0] {
        TO_OFF  = 3'b000,
        TO_ECHO = 3'b001,
        TO_OVF  = 3'b010
    } trgo_e;

    typedef enum logic [2:0] {
        TI_PEER = 3'b000,
        TI_CH1  = 3'b100
    } trgi_e;

    typedef struct packed {
        logic adv;
        logic wrap;
    } step_t;

    function automatic logic pick_trig(input logic [2:0] sel,
                                       input logic peer,
                                       input logic ch1);
        logic r;
        case (sel)
            TI_PEER: r = peer;
            TI_CH1:  r = ch1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ct_trig_in.sv
module ct_trig_in
    import casc_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    input  logic       peer,
    input  logic       ch1,
    input  logic       dly_en,
    output logic       rise_now,
    output logic       rise_evt
);
    localparam int DLY = SYNC_STAGES + 1;

    logic                   raw;
    logic [SYNC_STAGES:0]   shq;
    logic [DLY-1:0]         dq;

    assign raw = pick_trig(sel, peer, ch1);

    always_ff @(posedge clk) begin
        if (rst) begin
            shq <= '0;
            dq  <= '0;
        end else begin
            shq <= {shq[SYNC_STAGES-1:0], raw};
            dq  <= {dq[DLY-2:0], rise_now};
        end
    end

    assign rise_now = shq[SYNC_STAGES-1] & ~shq[SYNC_STAGES];
    assign rise_evt = dly_en ? dq[DLY-1] : rise_now;

endmodule

// File: rtl/ct_prescale.sv
module ct_prescale #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] div_in,
    output logic         tick
);
    localparam logic [W-1:0] ONE = 1;

    logic [W-1:0] div_act;
    logic [W-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_act <= div_in;
            pc      <= '0;
        end else begin
            if (load) div_act <= div_in;
            if (!run)               pc <= '0;
            else if (pc >= div_act) pc <= '0;
            else                    pc <= pc + ONE;
        end
    end

    assign tick = run && (pc >= div_act);

endmodule

// File: rtl/ct_counter.sv
module ct_counter
    import casc_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] per_in,
    output logic [W-1:0] cnt,
    output logic [W-1:0] per_act,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = 1;

    step_t st;

    assign st.adv  = adv;
    assign st.wrap = adv && (cnt >= per_act);
    assign wrap    = st.wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            per_act <= per_in;
        end else begin
            if (load) per_act <= per_in;
            if (st.wrap)     cnt <= '0;
            else if (st.adv) cnt <= cnt + ONE;
        end
    end

endmodule

// File: rtl/casc_timer.sv
module casc_timer
    import casc_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [CNT_W-1:0] div_val,
    input  logic [CNT_W-1:0] per_val,
    input  logic [2:0]       slave_mode,
    input  logic [2:0]       trgi_sel,
    input  logic             sync_hold,
    input  logic [2:0]       trgo_sel,
    input  logic             peer_trg_in,
    input  logic             ch1_in,
    output logic [CNT_W-1:0] cnt_out,
    output logic             trg_out,
    output logic             run_out
);
    logic             rise_now;
    logic             rise_evt;
    logic             tick;
    logic             adv;
    logic             wrap;
    logic             run;
    logic             load;
    logic             started_q;
    logic             trg_q;
    logic             ext_mode;
    logic             trig_mode;
    logic [CNT_W-1:0] per_cur;

    ct_trig_in #(.SYNC_STAGES(SYNC_STAGES)) u_tin (
        .clk      (clk),
        .rst      (rst),
        .sel      (trgi_sel),
        .peer     (peer_trg_in),
        .ch1      (ch1_in),
        .dly_en   (sync_hold),
        .rise_now (rise_now),
        .rise_evt (rise_evt)
    );

    assign ext_mode  = (slave_mode == SM_EXTCLK);
    assign trig_mode = (slave_mode == SM_TRIG);
    assign run       = run_en | started_q;
    assign load      = !run || wrap;

    ct_prescale #(.W(CNT_W)) u_psc (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .load   (load),
        .div_in (div_val),
        .tick   (tick)
    );

    assign adv = ext_mode ? (run & rise_evt) : tick;

    ct_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .load    (load),
        .per_in  (per_val),
        .cnt     (cnt_out),
        .per_act (per_cur),
        .wrap    (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst)                       started_q <= 1'b0;
        else if (trig_mode && rise_evt) started_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trg_q <= 1'b0;
        end else begin
            case (trgo_sel)
                TO_ECHO: trg_q <= rise_now;
                TO_OVF:  trg_q <= wrap;
                default: trg_q <= 1'b0;
            endcase
        end
    end

    assign trg_out = trg_q;
    assign run_out = run;

endmodule

// File: rtl/casc_timer_chk.sv
module casc_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cnt,
    input logic [W-1:0] per_cur,
    input logic         trg,
    input logic [2:0]   trgo_sel,
    input logic         run,
    input logic         started
);
    localparam logic [W-1:0] ONE = 1;

    logic [W-1:0] cnt_prev;
    logic [W-1:0] cnt_nx;
    logic [2:0]   sel_prev;

    always_ff @(posedge clk) begin
        cnt_prev <= cnt;
        sel_prev <= trgo_sel;
    end

    assign cnt_nx = cnt_prev + ONE;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != cnt_prev) |-> (cnt == cnt_nx || cnt == '0));

    // R2
    ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (trg && sel_prev == 3'b010) |-> (cnt == '0 || per_cur == '0 || cnt == ONE));

    // R7
    trg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_prev != 3'b001 && sel_prev != 3'b010) |-> !trg);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == $past(cnt)));

    // R4
    start_keep_chk: assert property (@(posedge clk) disable iff (rst)
        started |=> started);

endmodule

bind casc_timer casc_timer_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_out),
    .per_cur  (per_cur),
    .trg      (trg_out),
    .trgo_sel (trgo_sel),
    .run      (run_out),
    .started  (started_q)
);

// File: tb/casc_timer_tb.sv
module casc_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;

    logic        m_run_en = 0, s_run_en = 0;
    logic [15:0] m_div = 0, s_div = 0, m_per = 32, s_per = 22;
    logic [2:0]  m_mode = 0, s_mode = 0, m_tisel = 0, s_tisel = 0;
    logic [2:0]  m_tosel = 0, s_tosel = 0;
    logic        m_sync = 0, s_sync = 0, m_ch1 = 0;
    logic [15:0] m_cnt, s_cnt;
    logic        m_trg, s_trg, m_run, s_run;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    casc_timer u_dut (
        .clk(clk), .rst(rst), .run_en(m_run_en), .div_val(m_div), .per_val(m_per),
        .slave_mode(m_mode), .trgi_sel(m_tisel), .sync_hold(m_sync), .trgo_sel(m_tosel),
        .peer_trg_in(1'b0), .ch1_in(m_ch1), .cnt_out(m_cnt), .trg_out(m_trg), .run_out(m_run)
    );

    casc_timer u_peer (
        .clk(clk), .rst(rst), .run_en(s_run_en), .div_val(s_div), .per_val(s_per),
        .slave_mode(s_mode), .trgi_sel(s_tisel), .sync_hold(s_sync), .trgo_sel(s_tosel),
        .peer_trg_in(m_trg), .ch1_in(1'b0), .cnt_out(s_cnt), .trg_out(s_trg), .run_out(s_run)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic wait_pulse(output int c);
        do @(negedge clk); while (!m_trg);
        c = cyc;
    endtask

    // scoreboard state
    int exp_q[$];
    int pushed = 0;

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog act=0 exp=1");
        finish_run();
    end

    initial begin
        int c0, c1, c2, c3, cv;
        // ---- reset state (R8)
        do_reset();
        repeat (4) @(negedge clk);
        chk("R8 reset count", m_cnt, 0);
        chk("R8 reset trigger out", m_trg, 0);
        chk("R8 reset run", m_run, 0);

        // ---- overflow linking: master free-running, slave external clock
        m_run_en = 1; m_mode = 3'b000; m_tosel = 3'b010; m_div = 0; m_per = 32;
        s_run_en = 1; s_mode = 3'b111; s_tisel = 3'b000; s_tosel = 3'b000; s_per = 22; s_div = 0;
        do_reset();
        fork
            begin : driver
                int prev = 0;
                int s_exp = 0;
                for (int i = 0; i < 30; i++) begin
                    int c;
                    wait_pulse(c);
                    if (i > 0) chk("R1 master overflow spacing", c - prev, 33);
                    chk("R2 count is zero at pulse", m_cnt, 0);
                    s_exp = (s_exp + 1) % 23;
                    exp_q.push_back(s_exp);
                    pushed++;
                    @(negedge clk);
                    chk("R2 pulse width one clock", m_trg, 0);
                    prev = c;
                end
            end
            begin : monitor
                for (int i = 0; i < 30; i++) begin
                    int e;
                    wait (pushed > i);
                    repeat (3) @(posedge clk);
                    @(negedge clk);
                    e = exp_q.pop_front();
                    chk("R3 slave advances once per master overflow", s_cnt, e);
                end
            end
        join

        // ---- prescaler and shadowed period
        m_div = 1; m_per = 32; s_run_en = 0; s_mode = 3'b000;
        do_reset();
        wait_pulse(c0);
        wait_pulse(c1);
        chk("R9 prescaled overflow spacing", c1 - c0, 66);
        repeat (5) @(negedge clk);
        m_per = 10;
        wait_pulse(c2);
        chk("R11 current interval keeps old period", c2 - c1, 66);
        wait_pulse(c3);
        chk("R11 next interval uses new period", c3 - c2, 22);

        // ---- trigger start with sync bit set
        m_run_en = 0; m_mode = 3'b110; m_tisel = 3'b100; m_sync = 1; m_tosel = 3'b001;
        m_div = 0; m_per = 200; m_ch1 = 0;
        s_run_en = 0; s_mode = 3'b110; s_tisel = 3'b000; s_sync = 0; s_per = 200; s_tosel = 0;
        do_reset();
        repeat (5) @(negedge clk);
        chk("R8 stopped master holds zero", m_cnt, 0);
        chk("R8 stopped master run low", m_run, 0);
        m_ch1 = 1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R6 master count with sync", m_cnt, 4);
        chk("R6 slave count equals master", s_cnt, 4);
        m_ch1 = 0;
        repeat (3) @(negedge clk);
        m_ch1 = 1;
        repeat (8) @(negedge clk);
        cv = m_cnt;
        repeat (5) @(negedge clk);
        chk("R4 later edge does not restart", m_cnt, cv + 5);
        chk("R6 slave still aligned after later edge", s_cnt, m_cnt);

        // ---- trigger start without sync bit
        m_sync = 0; m_ch1 = 0;
        do_reset();
        repeat (2) @(negedge clk);
        m_ch1 = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 echo pulse one clock after detection", m_trg, 1);
        chk("R4 not yet counting", m_cnt, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 echo pulse ends", m_trg, 0);
        chk("R4 first count at third edge", m_cnt, 1);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R6 master leads without sync", m_cnt, 7);
        chk("R5 slave started via peer select", s_cnt, 4);

        // ---- free mode ignores trigger; unused select code
        m_mode = 3'b000; m_ch1 = 0;
        do_reset();
        for (int k = 0; k < 3; k++) begin
            repeat (3) @(negedge clk) m_ch1 = ~m_ch1;
        end
        repeat (6) @(negedge clk);
        chk("R10 free mode count stays zero", m_cnt, 0);
        chk("R10 free mode run stays low", m_run, 0);
        m_mode = 3'b110; m_tisel = 3'b011; m_ch1 = 0;
        repeat (3) @(negedge clk);
        m_ch1 = 1;
        repeat (8) @(negedge clk);
        chk("R5 unused select never starts", m_run, 0);
        chk("R5 unused select count zero", m_cnt, 0);

        finish_run();
    end

endmodule